// File: doc/BRIEF.md
# Byte-wide to reduced-pin double-rate Ethernet transmit adapter

This block sits between a MAC that hands over one byte per transmit clock, together with a transmit-enable and a transmit-error flag, and the reduced-pin gigabit interface toward a PHY. That interface has four data lines and a single control line, and it moves data on both clock edges. In gigabit mode each byte is split across the two halves of the clock cycle. The control line also changes meaning by clock phase: it carries the enable flag in the high phase and an encoded error flag in the low phase. In 10/100 mode the clock is slower and only one nibble moves per cycle. That nibble and the enable flag are repeated in both halves of the cycle.

The byte stream has no back-pressure. The enable flag acts as the valid qualifier, and the block accepts a new byte at every rising edge without stalling. There is no ready signal, so the MAC must supply a byte every cycle of the transmit clock. The clock itself runs at 125 MHz, 25 MHz or 2.5 MHz depending on link speed. A forwarded copy of it drives the PHY, and a parameter selects a 0 or 180 degree phase for that copy relative to the data.

Top module: `rgmii_tx_adapter`

## Requirements
- R1: While `rst` is high at a rising edge, the data and control outputs read 0 in both the high and the low phase that follow that edge.
- R2: In gigabit mode (`speed_gig`=1), the byte sampled at a rising edge drives its bits 3:0 on `rg_txd` during the high phase after that edge. Its bits 7:4 are driven during the low phase that follows.
- R3: In either mode, `rg_txctl` during the high phase after a rising edge equals the `gm_txen` sampled at that edge.
- R4: In gigabit mode, `rg_txctl` during the low phase equals `gm_txen` XOR `gm_txerr`, using the values sampled at the preceding rising edge.
- R5: An idle input (`gm_txen`=0, `gm_txerr`=0) drives `rg_txctl` low in both phases.
- R6: In 10/100 mode (`speed_gig`=0), bits 3:0 of the sampled byte appear on `rg_txd` in both phases. Bits 7:4 have no effect on any output.
- R7: In 10/100 mode, `rg_txctl` equals the sampled `gm_txen` in both phases. `gm_txerr` has no effect.
- R8: `speed_gig` is sampled with the byte at the same rising edge. A change of speed therefore applies from that byte on, with no lost or repeated cycle.
- R9: With `CLK_INVERT`=0, `rg_txc` is high in the high phase of `clk`. With `CLK_INVERT`=1, it is low in that phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock (125 / 25 / 2.5 MHz) |
| rst | input | 1 | Synchronous reset, active high |
| speed_gig | input | 1 | 1 = gigabit byte split, 0 = 10/100 nibble per cycle |
| gm_txd | input | 8 | Transmit byte |
| gm_txen | input | 1 | Transmit enable, acts as the byte's valid flag |
| gm_txerr | input | 1 | Transmit error flag |
| rg_txc | output | 1 | Forwarded transmit clock |
| rg_txd | output | 4 | Double-rate data nibble |
| rg_txctl | output | 1 | Multiplexed control line |

## Verification
The bench builds two instances. One uses the default `CLK_INVERT`=0 and the other uses `CLK_INVERT`=1. Together they cover both forwarded-clock phases against the same stimulus. The data path widths keep their default byte and nibble sizes, so every enable/error combination can be checked in both speed modes. This includes nonzero high nibbles and asserted error flags in 10/100 mode, where those inputs should have no effect. Speed switches and resets in the middle of the stream are also reachable with this configuration.

// File: rtl/rgtx_pkg.sv
package rgtx_pkg;
  localparam int DATA_W = 8;
  localparam int NIB_W  = DATA_W / 2;

  typedef struct packed {
    logic [NIB_W-1:0] nib;
    logic             ctl;
  } rgtx_half_t;

  function automatic logic fall_ctl(input logic en, input logic err);
    return en ^ err;
  endfunction
endpackage

// File: rtl/rgtx_capture.sv
module rgtx_capture
  import rgtx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              speed_gig,
  input  logic [DATA_W-1:0] txd,
  input  logic              txen,
  input  logic              txerr,
  output rgtx_half_t        rise_q,
  output rgtx_half_t        fall_pre_q,
  output logic              rst_q
);
  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) begin
      rise_q     <= '0;
      fall_pre_q <= '0;
    end else begin
      rise_q.nib <= txd[NIB_W-1:0];
      rise_q.ctl <= txen;
      if (speed_gig) begin
        fall_pre_q.nib <= txd[DATA_W-1:NIB_W];
        fall_pre_q.ctl <= fall_ctl(txen, txerr);
      end else begin
        fall_pre_q.nib <= txd[NIB_W-1:0];
        fall_pre_q.ctl <= txen;
      end
    end
  end

  // R1: reset empties both halves
  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (rise_q == '0 && fall_pre_q == '0));

  // R5: idle input keeps control low in both halves
  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (!txen && !txerr) |=> (!rise_q.ctl && !fall_pre_q.ctl));

  // R6 / R7: slow mode mirrors the rising half into the falling half
  p_slow_mirror_r6: assert property (@(posedge clk) disable iff (rst)
    !speed_gig |=> (fall_pre_q == rise_q));
endmodule

// File: rtl/rgtx_fall_hold.sv
module rgtx_fall_hold
  import rgtx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_q,
  input  rgtx_half_t fall_pre,
  output rgtx_half_t fall_q
);
  // Retimed on the falling edge so it stays stable across the low phase.
  always_ff @(negedge clk) begin
    if (rst_q) fall_q <= '0;
    else       fall_q <= fall_pre;
  end

  // R1: reset also clears the falling-edge holder
  p_hold_reset_r1: assert property (@(negedge clk)
    rst_q |=> (fall_q == '0));
endmodule

// File: rtl/rgtx_ddr_mux.sv
module rgtx_ddr_mux
  import rgtx_pkg::*;
#(
  parameter bit CLK_INVERT = 1'b0
) (
  input  logic             clk,
  input  rgtx_half_t       rise_h,
  input  rgtx_half_t       fall_h,
  output logic             txc,
  output logic [NIB_W-1:0] txd,
  output logic             txctl
);
  always_comb begin
    if (clk) begin
      txd   = rise_h.nib;
      txctl = rise_h.ctl;
    end else begin
      txd   = fall_h.nib;
      txctl = fall_h.ctl;
    end
  end

  generate
    if (CLK_INVERT) begin : g_clk_inv
      assign txc = ~clk;
    end else begin : g_clk_fwd
      assign txc = clk;
    end
  endgenerate
endmodule

// File: rtl/rgmii_tx_adapter.sv
module rgmii_tx_adapter
  import rgtx_pkg::*;
#(
  parameter bit CLK_INVERT = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              speed_gig,
  input  logic [DATA_W-1:0] gm_txd,
  input  logic              gm_txen,
  input  logic              gm_txerr,
  output logic              rg_txc,
  output logic [NIB_W-1:0]  rg_txd,
  output logic              rg_txctl
);
  rgtx_half_t rise_q, fall_pre_q, fall_q;
  logic       rst_q;

  rgtx_capture u_cap (
    .clk(clk), .rst(rst), .speed_gig(speed_gig),
    .txd(gm_txd), .txen(gm_txen), .txerr(gm_txerr),
    .rise_q(rise_q), .fall_pre_q(fall_pre_q), .rst_q(rst_q)
  );

  rgtx_fall_hold u_hold (
    .clk(clk), .rst_q(rst_q), .fall_pre(fall_pre_q), .fall_q(fall_q)
  );

  rgtx_ddr_mux #(.CLK_INVERT(CLK_INVERT)) u_mux (
    .clk(clk), .rise_h(rise_q), .fall_h(fall_q),
    .txc(rg_txc), .txd(rg_txd), .txctl(rg_txctl)
  );
endmodule

// File: tb/sim_rgmii_tx_adapter.sv
module sim_rgmii_tx_adapter;
  localparam int CLK_P = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       speed_gig = 1'b1;
  logic [7:0] gm_txd = '0;
  logic       gm_txen = 1'b0;
  logic       gm_txerr = 1'b0;
  logic       c0, c1, ctl0, ctl1;
  logic [3:0] d0, d1;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  typedef struct {
    logic [3:0] rn; logic rc;
    logic [3:0] fn; logic fc;
    string      tag;
  } exp_t;
  exp_t sb_q[$];

  always #(CLK_P/2) clk = ~clk;

  rgmii_tx_adapter #(.CLK_INVERT(1'b0)) u0 (
    .clk(clk), .rst(rst), .speed_gig(speed_gig), .gm_txd(gm_txd),
    .gm_txen(gm_txen), .gm_txerr(gm_txerr),
    .rg_txc(c0), .rg_txd(d0), .rg_txctl(ctl0));

  rgmii_tx_adapter #(.CLK_INVERT(1'b1)) u1 (
    .clk(clk), .rst(rst), .speed_gig(speed_gig), .gm_txd(gm_txd),
    .gm_txen(gm_txen), .gm_txerr(gm_txerr),
    .rg_txc(c1), .rg_txd(d1), .rg_txctl(ctl1));

  task automatic drive(input logic r, input logic sg, input logic [7:0] d,
                       input logic e, input logic er, input string tag);
    exp_t x;
    @(negedge clk);
    rst = r; speed_gig = sg; gm_txd = d; gm_txen = e; gm_txerr = er;
    if (r) begin
      x.rn = 4'h0; x.rc = 1'b0; x.fn = 4'h0; x.fc = 1'b0;
    end else if (sg) begin
      x.rn = d[3:0]; x.rc = e; x.fn = d[7:4]; x.fc = e ^ er;
    end else begin
      x.rn = d[3:0]; x.rc = e; x.fn = d[3:0]; x.fc = e;
    end
    x.tag = tag;
    sb_q.push_back(x);
  endtask

  // monitor: high phase at posedge + quarter, low phase at negedge + quarter
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      if (sb_q.size() > 0) begin
        exp_t x;
        logic [3:0] hn, hn1; logic hc, hc1, ck0h, ck1h;
        x = sb_q.pop_front();
        hn = d0; hc = ctl0; hn1 = d1; hc1 = ctl1; ck0h = c0; ck1h = c1;
        @(negedge clk);
        #(CLK_P/4);
        n_tests++;
        if (hn !== x.rn || hc !== x.rc || hn1 !== x.rn || hc1 !== x.rc) begin
          n_fail++;
          $display("FAIL %s high phase: got d=%h ctl=%b (inv d=%h ctl=%b) exp d=%h ctl=%b",
                   x.tag, hn, hc, hn1, hc1, x.rn, x.rc);
        end
        n_tests++;
        if (d0 !== x.fn || ctl0 !== x.fc || d1 !== x.fn || ctl1 !== x.fc) begin
          n_fail++;
          $display("FAIL %s low phase: got d=%h ctl=%b (inv d=%h ctl=%b) exp d=%h ctl=%b",
                   x.tag, d0, ctl0, d1, ctl1, x.fn, x.fc);
        end
        n_tests++; // R9: forwarded clock phase for both instances
        if (ck0h !== 1'b1 || ck1h !== 1'b0 || c0 !== 1'b0 || c1 !== 1'b1) begin
          n_fail++;
          $display("FAIL R9 clock: got hi(%b,%b) lo(%b,%b) exp hi(1,0) lo(0,1)",
                   ck0h, ck1h, c0, c1);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    drive(1, 1, 8'hA5, 1, 1, "R1");
    drive(1, 0, 8'h3C, 1, 0, "R1");
    // gigabit patterns
    drive(0, 1, 8'h00, 0, 0, "R5");
    drive(0, 1, 8'hA5, 1, 0, "R2");
    drive(0, 1, 8'h5A, 1, 0, "R2");
    drive(0, 1, 8'hF0, 1, 1, "R4");
    drive(0, 1, 8'h0F, 0, 1, "R4");
    drive(0, 1, 8'h96, 1, 0, "R3");
    drive(0, 1, 8'hFF, 0, 0, "R5");
    for (int i = 0; i < 16; i++)
      drive(0, 1, 8'(i * 37 + 11), i[0], i[1], "R2");
    // 10/100 patterns: high nibble and error must not matter
    drive(0, 0, 8'hE3, 1, 1, "R6");
    drive(0, 0, 8'h7C, 1, 0, "R6");
    drive(0, 0, 8'hF1, 0, 1, "R7");
    drive(0, 0, 8'h00, 0, 0, "R5");
    drive(0, 0, 8'hB9, 1, 1, "R7");
    // speed switches byte by byte
    drive(0, 1, 8'hC4, 1, 0, "R8");
    drive(0, 0, 8'hC4, 1, 1, "R8");
    drive(0, 1, 8'h2D, 1, 1, "R8");
    drive(0, 0, 8'hD2, 0, 0, "R8");
    // reset in mid-stream
    drive(0, 1, 8'h77, 1, 0, "R2");
    drive(1, 1, 8'h77, 1, 1, "R1");
    drive(0, 1, 8'h81, 1, 0, "R2");
    drive(0, 1, 8'h00, 0, 0, "R5");
    while (sb_q.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule